// File: doc/BRIEF.md
# Fence-Aware Issue Gate

This block sits between an in-order front end and an out-of-order back end. Each cycle it sees the class of the next instruction in program order and decides whether that instruction may issue. Most classes pass straight through when the back end is ready. The fence classes each leave a pending hold behind them, and that hold blocks later issue until a particular drain condition is seen.

The drain conditions are an empty reorder buffer and an empty store buffer. Both arrive as single-bit flags from the surrounding core. The read fence waits for the reorder buffer only. The full memory fence holds back later loads until the store buffer is empty; it can also be configured to wait for the reorder buffer. A serializing instruction waits for both flags at once. The store fence places no restriction on issue; it travels through the store buffer like an ordinary store.

A fence is itself granted in the cycle it is presented, provided no earlier hold blocks it. Its hold takes effect from the next cycle. A hold is released at a clock edge where its drain flags are high, so blocked instructions can issue in the cycle after that edge.

Top module: `fence_issue_gate`

## Requirements
- R1: Class codes on `in_class_i` are: 0 other, 1 load, 2 store, 3 read fence, 4 full fence, 5 store fence, 6 serializing. `in_ready_o` is `out_ready_i` AND NOT blocked. `issue_o` is `in_valid_i` AND `in_ready_o`. Both are combinational.
- R2: After a read fence issues, no instruction issues until the cycle after a clock edge at which `rob_empty_i` is high.
- R3: After a full fence issues, loads are blocked until the cycle after a clock edge at which `sb_empty_i` is high. Stores and all other classes are not held by this rule.
- R4: If `strong_mfence_i` is high when a full fence issues, that fence also blocks every class until the cycle after a clock edge at which `rob_empty_i` is high.
- R5: After a serializing instruction issues, no instruction issues until the cycle after a clock edge at which `rob_empty_i` and `sb_empty_i` are both high.
- R6: Loads, stores, other instructions and store fences leave no hold behind, whatever the flags are.
- R7: A fence presented with no hold pending is granted in that same cycle. Its hold starts in the following cycle.
- R8: Asserting `rst_ni` clears every pending hold.
- R9: A store fence followed by a read fence does not wait for the store buffer. Once the reorder buffer drains, a later load issues even while `sb_empty_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Front end presents an instruction |
| in_class_i | input | 3 | Instruction class code (see R1) |
| strong_mfence_i | input | 1 | Full fence also waits for the reorder buffer |
| rob_empty_i | input | 1 | Reorder buffer holds no instruction |
| sb_empty_i | input | 1 | Store buffer holds no entry |
| out_ready_i | input | 1 | Back end can accept an instruction |
| in_ready_o | output | 1 | Instruction may be taken this cycle |
| issue_o | output | 1 | Instruction issues this cycle |

## Verification
Some properties are checked on every cycle. Issue never happens without valid and ready. The cycle after a read fence or serializing instruction issues, nothing issues. The cycle after a full fence issues, no load issues. Each hold bit is set on arming and released when its drain condition is seen.

Other behaviours are shown only by the bench's sweeps over pairs of classes and drain-flag combinations. These include how long each hold lasts, the strong-mode variant, which classes pass a full fence, and the store-then-read-fence case in which a load overtakes a buffered store.

// File: rtl/fence_gate_pkg.sv
package fence_gate_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER  = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_STORE  = 3'd2,
    CLS_LFENCE = 3'd3,
    CLS_MFENCE = 3'd4,
    CLS_SFENCE = 3'd5,
    CLS_SERIAL = 3'd6
  } instr_cls_e;

  // hold kinds; index order is used by the generate loop in the top
  localparam int unsigned HOLD_ROB = 0;  // blocks all until rob empty
  localparam int unsigned HOLD_LD  = 1;  // blocks loads until sb empty
  localparam int unsigned HOLD_SER = 2;  // blocks all until both empty
  localparam int unsigned N_HOLD   = 3;
endpackage

// File: rtl/fence_decode.sv
module fence_decode
  import fence_gate_pkg::*;
(
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              strong_i,
  output logic [N_HOLD-1:0] arm_o,
  output logic              is_load_o
);
  always_comb begin
    arm_o     = '0;
    is_load_o = (cls_i == CLS_LOAD);
    unique case (cls_i)
      CLS_LFENCE: arm_o[HOLD_ROB] = 1'b1;
      CLS_MFENCE: begin
        arm_o[HOLD_LD]  = 1'b1;
        arm_o[HOLD_ROB] = strong_i;
      end
      CLS_SERIAL: arm_o[HOLD_SER] = 1'b1;
      default:    arm_o = '0;
    endcase
  end
endmodule

// File: rtl/fence_hold.sv
module fence_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // new arming wins over a release in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r7_hold_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r2_hold_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r6_hold_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/fence_issue_gate.sv
module fence_issue_gate
  import fence_gate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [CLS_W-1:0] in_class_i,
  input  logic             strong_mfence_i,
  input  logic             rob_empty_i,
  input  logic             sb_empty_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             issue_o
);
  logic [N_HOLD-1:0] arm, set_vec, clr_vec, hold_q;
  logic              is_load, blocked;

  fence_decode u_decode (
    .cls_i     (in_class_i),
    .strong_i  (strong_mfence_i),
    .arm_o     (arm),
    .is_load_o (is_load)
  );

  always_comb begin
    clr_vec           = '0;
    clr_vec[HOLD_ROB] = rob_empty_i;
    clr_vec[HOLD_LD]  = sb_empty_i;
    clr_vec[HOLD_SER] = rob_empty_i && sb_empty_i;
  end

  assign set_vec = issue_o ? arm : '0;

  for (genvar g = 0; g < N_HOLD; g++) begin : g_hold
    fence_hold u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .q_o    (hold_q[g])
    );
  end

  assign blocked    = hold_q[HOLD_ROB] || hold_q[HOLD_SER] ||
                      (hold_q[HOLD_LD] && is_load);
  assign in_ready_o = out_ready_i && !blocked;
  assign issue_o    = in_valid_i && in_ready_o;

  a_r1_grant_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (in_valid_i && out_ready_i));
  a_r2_lfence_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && in_class_i == CLS_LFENCE) |=> !issue_o);
  a_r3_mfence_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && in_class_i == CLS_MFENCE) |=> !(issue_o && in_class_i == CLS_LOAD));
  a_r4_strong_mfence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && in_class_i == CLS_MFENCE && strong_mfence_i) |=> !issue_o);
  a_r5_serial_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && in_class_i == CLS_SERIAL) |=> !issue_o);
  a_r6_sfence_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && in_class_i == CLS_SFENCE && hold_q == '0) |=> (hold_q == '0));
endmodule

// File: tb/fence_issue_gate_tb.sv
`timescale 1ns/1ps
module fence_issue_gate_tb;
  import fence_gate_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [2:0] in_class_i = 3'd0;
  logic       strong_mfence_i = 1'b0;
  logic       rob_empty_i = 1'b0;
  logic       sb_empty_i = 1'b0;
  logic       out_ready_i = 1'b1;
  logic       in_ready_o, issue_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fence_issue_gate u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .in_class_i(in_class_i), .strong_mfence_i(strong_mfence_i),
    .rob_empty_i(rob_empty_i), .sb_empty_i(sb_empty_i),
    .out_ready_i(out_ready_i), .in_ready_o(in_ready_o), .issue_o(issue_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected hold model: bit0 rob-wait all, bit1 sb-wait loads, bit2 wait both
  function automatic logic [2:0] arm_of(input logic [2:0] c, input logic st);
    arm_of = 3'b000;
    if (c == 3'd3) arm_of = 3'b001;
    if (c == 3'd4) arm_of = {1'b0, 1'b1, st};
    if (c == 3'd6) arm_of = 3'b100;
  endfunction

  function automatic logic blk(input logic [2:0] s, input logic [2:0] c);
    blk = s[0] || s[2] || (s[1] && c == 3'd1);
  endfunction

  function automatic logic [2:0] rel(input logic [2:0] s, input logic re, input logic se);
    rel = s;
    if (re) rel[0] = 1'b0;
    if (se) rel[1] = 1'b0;
    if (re && se) rel[2] = 1'b0;
  endfunction

  function automatic string tag_of(input logic [2:0] a, input logic st);
    case (a)
      3'd3: tag_of = "R2";
      3'd4: tag_of = st ? "R4" : "R3";
      3'd6: tag_of = "R5";
      default: tag_of = "R6";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    in_valid_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic present(input logic [2:0] c, input logic re, input logic se);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_class_i = c; rob_empty_i = re; sb_empty_i = se;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    logic [2:0] s;
    logic e1;
    do_reset();

    // R8: reset state, a load issues with nothing drained
    present(3'd1, 1'b0, 1'b0);
    check("R8 reset idle", issue_o, 1'b1);

    // R1: back-end not ready -> no grant, no ready
    out_ready_i = 1'b0;
    present(3'd0, 1'b0, 1'b0);
    check("R1 ready low issue", issue_o, 1'b0);
    check("R1 ready low in_ready", in_ready_o, 1'b0);
    out_ready_i = 1'b1;
    in_valid_i = 1'b0; #0.5;
    check("R1 valid low", issue_o, 1'b0);
    check("R1 ready w/o valid", in_ready_o, 1'b1);

    // R8: reset drops a pending serializing hold
    present(3'd6, 1'b0, 1'b0);
    check("R7 serial granted", issue_o, 1'b1);
    do_reset();
    present(3'd1, 1'b0, 1'b0);
    check("R8 hold cleared", issue_o, 1'b1);

    // sweep: first class A, strong mode, second class B, drain flags
    for (int st = 0; st < 2; st++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++)
          for (int f = 0; f < 4; f++) begin
            do_reset();
            strong_mfence_i = st[0];
            present(a[2:0], 1'b0, 1'b0);
            check("R7 first granted", issue_o, 1'b1);
            s = arm_of(a[2:0], st[0]);
            present(b[2:0], f[0], f[1]);
            e1 = !blk(s, b[2:0]);
            check(tag_of(a[2:0], st[0]), issue_o, e1);
            check("R1 in_ready", in_ready_o, e1);
            s = rel(s, f[0], f[1]) | (e1 ? arm_of(b[2:0], st[0]) : 3'b000);
            present(b[2:0], 1'b0, 1'b0);
            check(tag_of(a[2:0], st[0]), issue_o, !blk(s, b[2:0]));
            in_valid_i = 1'b0;
          end
    strong_mfence_i = 1'b0;

    // R9: store fence then read fence; load passes a non-empty store buffer
    do_reset();
    present(3'd2, 1'b0, 1'b0);
    present(3'd5, 1'b0, 1'b0);
    check("R9 sfence granted", issue_o, 1'b1);
    present(3'd3, 1'b0, 1'b0);
    check("R9 lfence granted", issue_o, 1'b1);
    present(3'd1, 1'b0, 1'b0);
    check("R9 load held by rob", issue_o, 1'b0);
    present(3'd1, 1'b1, 1'b0);
    check("R9 load held until edge", issue_o, 1'b0);
    present(3'd1, 1'b0, 1'b0);
    check("R9 load passes store", issue_o, 1'b1);

    // R5: serializing hold needs both flags in the same cycle
    do_reset();
    present(3'd6, 1'b0, 1'b0);
    present(3'd0, 1'b1, 1'b0);
    present(3'd0, 1'b0, 1'b1);
    check("R5 split drain", issue_o, 1'b0);
    present(3'd0, 1'b1, 1'b1);
    present(3'd0, 1'b0, 1'b0);
    check("R5 joint drain", issue_o, 1'b1);

    // R3: stores keep flowing behind a full fence while loads wait
    do_reset();
    present(3'd4, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      present(3'd2, 1'b0, 1'b0);
      check("R3 store passes", issue_o, 1'b1);
    end
    present(3'd1, 1'b0, 1'b0);
    check("R3 load waits", issue_o, 1'b0);
    in_valid_i = 1'b0;

    finish_run();
  end
endmodule